// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the control half of a small out-of-order core that does not rename registers. Instructions come in program order on a dispatch stream. Each one carries an operation class, a destination register name and two source register names. The block holds one status entry per functional unit and a status tag per architectural register. Each cycle it decides three things: whether the incoming instruction may take a unit, which waiting instruction may read the register file and start, and which finished units may write their result. The functional units themselves are latency counters started by the issue decision. No data passes through the block.

The dispatch side is a valid/ready stream. `disp_ready` depends only on the instruction's class and destination and on the block's state, never on `disp_valid`. An instruction counts as accepted in a cycle where both are high. While ready is low the sender must hold valid and the payload steady. Issue and writeback are single-cycle pulses with no back-pressure. Unit IDs are 1 for the ALU, 2 for the load unit, 3 for the store unit, and 4 upward for the floating-point units. Tag 0 means the register value is present in the register file.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset no unit is busy, no issue or writeback is signalled, and an instruction of any class is accepted at once.
- R2: Class codes are 0 ALU, 1 load, 2 store and 3 floating point. An instruction is accepted only if a unit of its class is idle or is writing back in that cycle. Among floating-point units the lowest free ID is taken, and `disp_unit` reports the ID assigned.
- R3: An instruction with a destination is held while that register's status tag is nonzero, unless the unit named by the tag writes back in the same cycle.
- R4: An entry issues only when both source tags are zero, or are cleared by a writeback in that same cycle.
- R5: A finished unit does not write back while any entry that has not yet issued reads the unit's destination register with a zero tag.
- R6: A unit issued in cycle t requests writeback in cycle t+LAT+1, where LAT is 1 for the ALU, load and store units and 3 for floating point. It writes back in that cycle unless R5 holds it.
- R7: At most one entry issues per cycle. When several are ready, the one dispatched earliest goes first, whatever its unit ID.
- R8: Several units may write back in the same cycle. Bit u-1 of `wb_mask` is set for unit u.
- R9: A unit that writes back in a cycle can accept a new instruction in that same cycle.
- R10: A store has no destination. Its `disp_dst` field is ignored, it is never held by R3, and it marks no register as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch payload valid |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_cls | input | 2 | Operation class (0 ALU, 1 load, 2 store, 3 FP) |
| disp_dst | input | REG_W | Destination register name |
| disp_src1 | input | REG_W | First source register name |
| disp_src2 | input | REG_W | Second source register name |
| disp_unit | output | TAG_W | Unit ID the instruction would be given |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_unit | output | TAG_W | Unit ID of the issuing entry |
| wb_mask | output | NFU | Units writing back this cycle |

## Verification
The hardest situation to reach is a writeback held by a write-after-read hazard while, in the same window, a dispatch stalls on a write-after-write hazard and is then released in the very cycle the earlier writer drains. The bench gets there by replaying a two-iteration load, multiply, store and increment loop. In that loop the increment finishes before the store has read the old index register. Separate short sequences line up two consumers of one load so that they become ready together in both dispatch orders. Other sequences issue an ALU operation and a floating-point operation so that they finish in the same cycle, fill both floating-point units, and hide a store's unused destination behind an in-flight load.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LD  = 2'd1,
    CLS_ST  = 2'd2,
    CLS_FP  = 2'd3
  } op_cls_e;

  // unit index (0-based) to operation class: fixed ALU, load, store, then FP units
  function automatic op_cls_e unit_cls(input int u);
    case (u)
      0:       return CLS_ALU;
      1:       return CLS_LD;
      2:       return CLS_ST;
      default: return CLS_FP;
    endcase
  endfunction
endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot #(
  parameter int NFU   = 5,
  parameter int TAG_W = 3,
  parameter int REG_W = 4,
  parameter int CNT_W = 2,
  parameter int LAT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src1,
  input  logic [REG_W-1:0] a_src2,
  input  logic [TAG_W-1:0] a_t1,
  input  logic [TAG_W-1:0] a_t2,
  input  logic             issue,
  input  logic             wb_go,
  input  logic [NFU:0]     wb_any,
  output logic             busy,
  output logic             issued,
  output logic             done,
  output logic             ready,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] src1,
  output logic [REG_W-1:0] src2,
  output logic [TAG_W-1:0] t1,
  output logic [TAG_W-1:0] t2
);
  logic [CNT_W-1:0] cnt;
  logic ok1, ok2;

  // a source is usable if already clear or its producer drains this cycle
  assign ok1   = (t1 == '0) || wb_any[t1];
  assign ok2   = (t2 == '0) || wb_any[t2];
  assign ready = busy && !issued && ok1 && ok2;
  assign done  = issued && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      issued <= 1'b0;
      cnt    <= '0;
      dst    <= '0;
      src1   <= '0;
      src2   <= '0;
      t1     <= '0;
      t2     <= '0;
    end else if (alloc) begin
      busy   <= 1'b1;
      issued <= 1'b0;
      cnt    <= '0;
      dst    <= a_dst;
      src1   <= a_src1;
      src2   <= a_src2;
      t1     <= a_t1;
      t2     <= a_t2;
    end else if (wb_go) begin
      busy   <= 1'b0;
      issued <= 1'b0;
    end else begin
      if (issue) begin
        issued <= 1'b1;
        cnt    <= CNT_W'(LAT);
      end else if (issued && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (t1 != '0 && wb_any[t1]) t1 <= '0;
      if (t2 != '0 && wb_any[t2]) t2 <= '0;
    end
  end
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NREG  = 16,
  parameter int NFU   = 5,
  parameter int REG_W = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [NFU-1:0]   clr_en,
  input  logic [REG_W-1:0] clr_reg [NFU],
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic [REG_W-1:0] rd_d,
  output logic [TAG_W-1:0] tag_a,
  output logic [TAG_W-1:0] tag_b,
  output logic [TAG_W-1:0] tag_d
);
  logic [TAG_W-1:0] stat [NREG];
  logic [NREG-1:0]  clr_hit;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      clr_hit[r] = 1'b0;
      for (int u = 0; u < NFU; u++)
        if (clr_en[u] && clr_reg[u] == REG_W'(r) && stat[r] == TAG_W'(u + 1))
          clr_hit[r] = 1'b1;
    end
  end

  // a new claim in the same cycle overrides the release of the old writer
  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n)                                stat[r] <= '0;
      else if (set_en && set_reg == REG_W'(r))   stat[r] <= set_tag;
      else if (clr_hit[r])                       stat[r] <= '0;
    end
  end

  assign tag_a = stat[rd_a];
  assign tag_b = stat[rd_b];
  assign tag_d = stat[rd_d];
endmodule

// File: rtl/sb_age_pick.sv
module sb_age_pick #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] busy,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // older[i][j] set: entry i was dispatched before entry j
  logic [N-1:0] older [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_vec[k]) begin
          older[k] <= '0;
          for (int i = 0; i < N; i++)
            if (i != k) older[i][k] <= busy[i];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i];
      for (int j = 0; j < N; j++)
        if (j != i && req[j] && older[j][i]) gnt[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int  N_FP    = 2,
  parameter int  NREG    = 16,
  parameter int  LAT_ALU = 1,
  parameter int  LAT_LD  = 1,
  parameter int  LAT_ST  = 1,
  parameter int  LAT_FP  = 3,
  localparam int NFU     = 3 + N_FP,
  localparam int TAG_W   = $clog2(NFU + 1),
  localparam int REG_W   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [1:0]       disp_cls,
  input  logic [REG_W-1:0] disp_dst,
  input  logic [REG_W-1:0] disp_src1,
  input  logic [REG_W-1:0] disp_src2,
  output logic [TAG_W-1:0] disp_unit,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_unit,
  output logic [NFU-1:0]   wb_mask
);
  localparam int LAT_M1  = (LAT_ALU > LAT_LD) ? LAT_ALU : LAT_LD;
  localparam int LAT_M2  = (LAT_ST > LAT_FP) ? LAT_ST : LAT_FP;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [NFU-1:0]   fu_busy, fu_issued, fu_done, fu_ready, fu_has_dst;
  logic [NFU-1:0]   wb_go, war_block, gnt, alloc_vec;
  logic [REG_W-1:0] s_dst [NFU];
  logic [REG_W-1:0] s_src1 [NFU];
  logic [REG_W-1:0] s_src2 [NFU];
  logic [TAG_W-1:0] s_t1 [NFU];
  logic [TAG_W-1:0] s_t2 [NFU];
  logic [NFU:0]     wbx;
  logic [TAG_W-1:0] tag_a, tag_b, tag_d, new_t1, new_t2, pick_id;
  logic             pick_ok, need_dst, waw, accept;
  op_cls_e          cls;

  assign cls      = op_cls_e'(disp_cls);
  assign wbx      = {wb_go, 1'b0};
  assign need_dst = (cls != CLS_ST);

  // unit selection: lowest-numbered free unit of the requested class
  always_comb begin
    pick_ok = 1'b0;
    pick_id = '0;
    for (int u = 0; u < NFU; u++) begin
      if (!pick_ok && unit_cls(u) == cls && (!fu_busy[u] || wb_go[u])) begin
        pick_ok = 1'b1;
        pick_id = TAG_W'(u + 1);
      end
    end
  end

  assign waw        = need_dst && (tag_d != '0) && !wbx[tag_d];
  assign disp_ready = pick_ok && !waw;
  assign disp_unit  = pick_id;
  assign accept     = disp_valid && disp_ready;
  assign new_t1     = wbx[tag_a] ? '0 : tag_a;
  assign new_t2     = wbx[tag_b] ? '0 : tag_b;

  // write-after-read: an unissued reader still needs the old register value
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_block[u] = 1'b0;
      for (int v = 0; v < NFU; v++) begin
        if (fu_busy[v] && !fu_issued[v] &&
            ((s_src1[v] == s_dst[u] && s_t1[v] == '0) ||
             (s_src2[v] == s_dst[u] && s_t2[v] == '0)))
          war_block[u] = 1'b1;
      end
    end
  end

  assign wb_go   = fu_done & ~(war_block & fu_has_dst);
  assign wb_mask = wb_go;

  always_comb begin
    iss_unit = '0;
    for (int u = 0; u < NFU; u++)
      if (gnt[u]) iss_unit = TAG_W'(u + 1);
  end
  assign iss_valid = |gnt;

  for (genvar u = 0; u < NFU; u++) begin : g_unit
    localparam int LAT_U = (u == 0) ? LAT_ALU : (u == 1) ? LAT_LD :
                           (u == 2) ? LAT_ST  : LAT_FP;
    assign fu_has_dst[u] = (u != 2);
    assign alloc_vec[u]  = accept && (pick_id == TAG_W'(u + 1));

    sb_fu_slot #(
      .NFU(NFU), .TAG_W(TAG_W), .REG_W(REG_W), .CNT_W(CNT_W), .LAT(LAT_U)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[u]), .a_dst(disp_dst), .a_src1(disp_src1), .a_src2(disp_src2),
      .a_t1(new_t1), .a_t2(new_t2),
      .issue(gnt[u]), .wb_go(wb_go[u]), .wb_any(wbx),
      .busy(fu_busy[u]), .issued(fu_issued[u]), .done(fu_done[u]), .ready(fu_ready[u]),
      .dst(s_dst[u]), .src1(s_src1[u]), .src2(s_src2[u]), .t1(s_t1[u]), .t2(s_t2[u])
    );
  end

  sb_regstat #(
    .NREG(NREG), .NFU(NFU), .REG_W(REG_W), .TAG_W(TAG_W)
  ) u_regstat (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept && need_dst), .set_reg(disp_dst), .set_tag(pick_id),
    .clr_en(wb_go & fu_has_dst), .clr_reg(s_dst),
    .rd_a(disp_src1), .rd_b(disp_src2), .rd_d(disp_dst),
    .tag_a(tag_a), .tag_b(tag_b), .tag_d(tag_d)
  );

  sb_age_pick #(.N(NFU)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .alloc_vec(alloc_vec), .busy(fu_busy), .req(fu_ready), .gnt(gnt)
  );
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk #(
  parameter int NFU   = 5,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [TAG_W-1:0] disp_unit,
  input logic             iss_valid,
  input logic [TAG_W-1:0] iss_unit,
  input logic [NFU-1:0]   wb_mask,
  input logic [NFU-1:0]   fu_busy,
  input logic [NFU-1:0]   fu_issued
);
  logic [NFU:0] busy_x, iss_x, wbm_x;
  assign busy_x = {fu_busy, 1'b0};
  assign iss_x  = {fu_issued, 1'b0};
  assign wbm_x  = {wb_mask, 1'b0};

  a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |-> (!busy_x[disp_unit] || wbm_x[disp_unit]));

  a_r7_issue_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_unit != '0 && busy_x[iss_unit] && !iss_x[iss_unit]));

  a_r6_wb_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_mask & ~fu_issued) == '0);

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    a_r9_free_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_mask[u] && !(disp_valid && disp_ready && disp_unit == TAG_W'(u + 1)))
        |=> !fu_busy[u]);

    a_r6_exec_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_issued[u] && !wb_mask[u]) |=> fu_issued[u]);
  end
endmodule

bind sb_issue_ctrl sb_issue_chk #(.NFU(NFU), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/test_sb_issue_ctrl.sv
module test_sb_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic       disp_ready;
  logic [1:0] disp_cls = 2'd0;
  logic [3:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic [2:0] disp_unit;
  logic       iss_valid;
  logic [2:0] iss_unit;
  logic [4:0] wb_mask;

  int cyc = 0, base = 0, n_run = 0, n_fail = 0;
  bit finished = 0;
  int acc_log [32], iss_log [32], wb_log [32];
  int acc_exp [32], iss_exp [32], wb_exp [32];

  sb_issue_ctrl i_sb_issue_ctrl (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    int rel;
    rel = cyc - base;
    if (rel >= 1 && rel < 32) begin
      acc_log[rel] = (disp_valid && disp_ready) ? int'(disp_unit) : 0;
      iss_log[rel] = iss_valid ? int'(iss_unit) : 0;
      wb_log[rel]  = int'(wb_mask);
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic start_scn();
    for (int c = 0; c < 32; c++) begin
      acc_log[c] = 0; iss_log[c] = 0; wb_log[c] = 0;
      acc_exp[c] = 0; iss_exp[c] = 0; wb_exp[c] = 0;
    end
    @(posedge clk); #1;
    base = cyc - 1;
  endtask

  task automatic send(int cls, int dst, int s1, int s2);
    disp_valid = 1'b1;
    disp_cls = 2'(cls); disp_dst = 4'(dst); disp_src1 = 4'(s1); disp_src2 = 4'(s2);
    @(negedge clk);
    while (!disp_ready) @(negedge clk);
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic end_scn(string name, string ra, string ri, string rw);
    repeat (30) @(posedge clk);
    #1;
    for (int c = 1; c < 31; c++) begin
      chk(ra, $sformatf("%s accept c%0d", name, c), acc_log[c], acc_exp[c]);
      chk(ri, $sformatf("%s issue c%0d", name, c), iss_log[c], iss_exp[c]);
      chk(rw, $sformatf("%s wb c%0d", name, c), wb_log[c], wb_exp[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    disp_cls = 2'd3;
    #0.5;
    chk("R1", "ready fp", int'(disp_ready), 1);
    chk("R1", "unit fp", int'(disp_unit), 4);
    chk("R1", "issue", int'(iss_valid), 0);
    chk("R1", "wb", int'(wb_mask), 0);
    disp_cls = 2'd0;
    #0.5;
    chk("R1", "unit alu", int'(disp_unit), 1);

    // A: two-iteration loop; regs f0=1 f1=2 f2=3 r1=4 (R3 WAW, R4 RAW, R5 WAR)
    start_scn();
    acc_exp[1]=2; acc_exp[2]=4; acc_exp[3]=3; acc_exp[4]=1; acc_exp[5]=2; acc_exp[8]=4; acc_exp[10]=3;
    iss_exp[2]=2; iss_exp[4]=4; iss_exp[5]=1; iss_exp[8]=3; iss_exp[9]=2; iss_exp[11]=4; iss_exp[15]=3;
    wb_exp[4]=2; wb_exp[8]=8; wb_exp[9]=1; wb_exp[10]=4; wb_exp[11]=2; wb_exp[15]=8; wb_exp[17]=4;
    send(1, 2, 4, 4); send(3, 3, 1, 2); send(2, 0, 3, 4); send(0, 4, 4, 4);
    send(1, 2, 4, 4); send(3, 3, 1, 2); send(2, 0, 3, 4);
    end_scn("loop", "R3", "R4", "R5");

    // B: two consumers of one load, FP dispatched first (R7 oldest first, R6 latency)
    start_scn();
    acc_exp[1]=2; acc_exp[2]=4; acc_exp[3]=1;
    iss_exp[2]=2; iss_exp[4]=4; iss_exp[5]=1;
    wb_exp[4]=2; wb_exp[7]=1; wb_exp[8]=8;
    send(1, 5, 0, 0); send(3, 6, 5, 5); send(0, 7, 5, 5);
    end_scn("age_fp_first", "R2", "R7", "R6");

    // C: same consumers, ALU dispatched first
    start_scn();
    acc_exp[1]=2; acc_exp[2]=1; acc_exp[3]=4;
    iss_exp[2]=2; iss_exp[4]=1; iss_exp[5]=4;
    wb_exp[4]=2; wb_exp[6]=1; wb_exp[9]=8;
    send(1, 5, 0, 0); send(0, 7, 5, 5); send(3, 6, 5, 5);
    end_scn("age_alu_first", "R2", "R7", "R6");

    // D: both FP units full, simultaneous writebacks, reuse of freed unit (R8, R9, R2)
    start_scn();
    acc_exp[1]=4; acc_exp[2]=5; acc_exp[3]=1; acc_exp[6]=4;
    iss_exp[2]=4; iss_exp[3]=5; iss_exp[4]=1; iss_exp[7]=4;
    wb_exp[6]=9; wb_exp[7]=16; wb_exp[11]=8;
    send(3, 1, 0, 0); send(3, 2, 0, 0); send(0, 3, 0, 0); send(3, 4, 0, 0);
    end_scn("fp_full", "R9", "R2", "R8");

    // E: WAW hold released in the producer's writeback cycle (R3)
    start_scn();
    acc_exp[1]=2; acc_exp[4]=1;
    iss_exp[2]=2; iss_exp[5]=1;
    wb_exp[4]=2; wb_exp[7]=1;
    send(1, 5, 0, 0); send(0, 5, 0, 0);
    end_scn("waw", "R3", "R4", "R6");

    // F: store's destination field ignored while a load owns that register (R10)
    start_scn();
    acc_exp[1]=2; acc_exp[2]=3;
    iss_exp[2]=2; iss_exp[3]=3;
    wb_exp[4]=2; wb_exp[5]=4;
    send(1, 5, 0, 0); send(2, 5, 6, 6);
    end_scn("store", "R10", "R10", "R10");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule